// File: doc/BRIEF.md
# RAM Bank Zeroization Engine

This block wipes whole system RAM banks on request. Software writes a four-bit select word, one bit per bank. The engine then walks every 32-bit word of each selected bank and issues a write of zero for each word on a plain SRAM write port. The port has an address, write data, a write enable and a ready input. The four banks sit back to back in one byte address space and have unequal sizes. Bank 0 and bank 1 are 32 KiB each and start at byte 0x0 and 0x8000. Bank 2 is 48 KiB and starts at 0x10000. Bank 3 is 16 KiB and starts at 0x1C000.

Selected banks are cleared in ascending index order. The pending-request word can be read at any time. Each of its bits stays set until that bank has been fully written, and then clears itself. A one-cycle completion pulse marks the end of the whole job. While the engine is working, software may post more banks; only banks with a higher index than the one being cleared are added to the job.

Top module: `wipe_engine`

## Requirements
- R1: While reset is asserted and in the first cycle after it, busy, done, the write enable and every pending bit are 0.
- R2: A request strobe with a nonzero select word while idle makes busy 1 and loads the pending word with the select word on the next cycle; bit i of the select word selects bank i. A strobe with an all-zero select word while idle changes nothing.
- R3: While busy, the address lies inside the active bank, the data is zero, and each accepted write moves the address up by 4. Bank i covers [base, base+size) with bases 0x0, 0x8000, 0x10000, 0x1C000 and sizes 0x8000, 0x8000, 0xC000, 0x4000 bytes. Every word of a selected bank is written exactly once.
- R4: A cycle with ready low accepts no write: the address and the write enable hold for the next cycle.
- R5: Selected banks are cleared in ascending index order, and unselected banks are skipped.
- R6: The pending bit of a bank reads 1 from its request until the cycle after its last word is accepted, and then reads 0. The active bank's pending bit is always 1 while busy.
- R7: In the cycle after the last word of the last pending bank is accepted, busy is 0, the pending word is 0 and done is 1 for exactly one cycle.
- R8: A request strobe while busy adds, on the next cycle, the selected banks whose index is above the active bank, and those banks are cleared in this job.
- R9: A request strobe while busy is ignored for the active bank and for lower-indexed banks: they are not added to the pending word and are not written again.
- R10: The write enable is 1 exactly in the cycles where busy is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_wr | input | 1 | Request strobe, one cycle per control write |
| req_mask | input | 4 | Bank select word; bit i picks bank i |
| pend_mask | output | 4 | Banks still awaiting clearing |
| busy | output | 1 | Engine is clearing |
| done | output | 1 | One-cycle pulse when the job is finished |
| mem_addr | output | 17 | Byte address of the current zero write |
| mem_wdata | output | 32 | Write data, always zero |
| mem_we | output | 1 | Write enable |
| mem_ready | input | 1 | Memory accepts the write at this edge |

## Verification
The busy and pending words respond one edge after a request strobe. The address moves one edge after each accepted write. A pending bit falls, and done rises, one edge after the final accepted word of a bank or of the job. The bench drives the strobe and the ready input at the falling edge. At that same falling edge it compares the outputs with a cycle model advanced once per edge. So every result is compared in the first half-cycle in which it is due. The bench also counts the words it actually sees written in each bank, and the order in which banks appear, and checks both at the end of each job.

// File: rtl/wipe_pkg.sv
package wipe_pkg;
  localparam int NBANK = 4;

  typedef logic [NBANK-1:0]             mask_t;
  typedef logic [$clog2(NBANK)-1:0]     bank_t;
  typedef logic [NBANK-1:0][31:0]       size_vec_t;

  // bank byte sizes, element 0 = bank 0
  localparam size_vec_t DEF_BANK_BYTES = {32'h0000_4000, 32'h0000_C000,
                                          32'h0000_8000, 32'h0000_8000};

  // start byte of each bank, banks packed back to back
  function automatic size_vec_t base_vec(size_vec_t sz);
    size_vec_t v;
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < NBANK; i++) begin
      v[i] = acc;
      acc  = acc + sz[i];
    end
    return v;
  endfunction

  // index of the final word of each bank
  function automatic size_vec_t last_vec(size_vec_t sz, int wshift);
    size_vec_t v;
    for (int i = 0; i < NBANK; i++) v[i] = (sz[i] >> wshift) - 32'd1;
    return v;
  endfunction

  function automatic logic [31:0] total_bytes(size_vec_t sz);
    logic [31:0] acc;
    acc = '0;
    for (int i = 0; i < NBANK; i++) acc = acc + sz[i];
    return acc;
  endfunction

  function automatic logic [31:0] max_words(size_vec_t sz, int wshift);
    logic [31:0] m;
    m = '0;
    for (int i = 0; i < NBANK; i++) if ((sz[i] >> wshift) > m) m = sz[i] >> wshift;
    return m;
  endfunction

  // lowest set bit of a mask
  function automatic bank_t first_set(mask_t m);
    bank_t f;
    f = '0;
    for (int i = NBANK - 1; i >= 0; i--) if (m[i]) f = bank_t'(i);
    return f;
  endfunction

  // banks with a strictly higher index than b
  function automatic mask_t above(bank_t b);
    mask_t m;
    for (int i = 0; i < NBANK; i++) m[i] = (i > int'(b));
    return m;
  endfunction

  function automatic mask_t onehot(bank_t b);
    mask_t m;
    m = '0;
    m[b] = 1'b1;
    return m;
  endfunction
endpackage

// File: rtl/wipe_sched.sv
module wipe_sched
  import wipe_pkg::*;
(
  input  logic  clk,
  input  logic  rst_n,
  input  logic  req_wr,
  input  mask_t req_mask,
  input  logic  bank_end,
  output mask_t pend,
  output logic  busy,
  output logic  done,
  output bank_t cur_bank
);
  mask_t pend_q, pend_n, clr_m, add_m;
  bank_t cur_q;
  logic  busy_q, done_q;
  logic  start_ev;

  assign start_ev = !busy_q && req_wr && (|req_mask);

  always_comb begin
    clr_m  = bank_end ? onehot(cur_q) : '0;
    add_m  = (busy_q && req_wr) ? (req_mask & above(cur_q)) : '0;
    pend_n = (pend_q & ~clr_m) | add_m;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pend_q <= '0;
      cur_q  <= '0;
      busy_q <= 1'b0;
      done_q <= 1'b0;
    end else begin
      done_q <= 1'b0;
      if (!busy_q) begin
        if (start_ev) begin
          pend_q <= req_mask;
          cur_q  <= first_set(req_mask);
          busy_q <= 1'b1;
        end
      end else begin
        pend_q <= pend_n;
        if (bank_end) begin
          if (pend_n == '0) begin
            busy_q <= 1'b0;
            done_q <= 1'b1;
          end else begin
            cur_q <= first_set(pend_n);
          end
        end
      end
    end
  end

  assign pend     = pend_q;
  assign busy     = busy_q;
  assign done     = done_q;
  assign cur_bank = cur_q;
endmodule

// File: rtl/wipe_addr.sv
module wipe_addr
  import wipe_pkg::*;
#(
  parameter size_vec_t BANK_BYTES = DEF_BANK_BYTES,
  parameter int        ADDR_W     = 17,
  parameter int        WSHIFT     = 2
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              busy,
  input  logic              mem_ready,
  input  bank_t             cur_bank,
  output logic [ADDR_W-1:0] mem_addr,
  output logic              last_word,
  output logic              bank_end
);
  localparam size_vec_t   BASE_V = base_vec(BANK_BYTES);
  localparam size_vec_t   LAST_V = last_vec(BANK_BYTES, WSHIFT);
  localparam logic [31:0] MAXW   = max_words(BANK_BYTES, WSHIFT);
  localparam int          OFF_W  = (MAXW > 1) ? $clog2(MAXW) : 1;

  logic [OFF_W-1:0] off_q;
  logic             step;

  assign step      = busy && mem_ready;
  assign last_word = (off_q == LAST_V[cur_bank][OFF_W-1:0]);
  assign bank_end  = step && last_word;

  // offset returns to zero after each bank, so a new bank starts at its base
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)    off_q <= '0;
    else if (step) off_q <= last_word ? '0 : off_q + 1'b1;
  end

  assign mem_addr = BASE_V[cur_bank][ADDR_W-1:0] + (ADDR_W'(off_q) << WSHIFT);
endmodule

// File: rtl/wipe_engine.sv
module wipe_engine
  import wipe_pkg::*;
#(
  parameter int        DATA_W     = 32,
  parameter size_vec_t BANK_BYTES = DEF_BANK_BYTES,
  localparam int       ADDR_W     = $clog2(total_bytes(BANK_BYTES)),
  localparam int       WSHIFT     = $clog2(DATA_W / 8)
)(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_wr,
  input  logic [NBANK-1:0]  req_mask,
  output logic [NBANK-1:0]  pend_mask,
  output logic              busy,
  output logic              done,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [DATA_W-1:0] mem_wdata,
  output logic              mem_we,
  input  logic              mem_ready
);
  bank_t cur_bank;
  logic  last_word;
  logic  bank_end;

  wipe_sched u_sched (
    .clk      (clk),
    .rst_n    (rst_n),
    .req_wr   (req_wr),
    .req_mask (req_mask),
    .bank_end (bank_end),
    .pend     (pend_mask),
    .busy     (busy),
    .done     (done),
    .cur_bank (cur_bank)
  );

  wipe_addr #(
    .BANK_BYTES (BANK_BYTES),
    .ADDR_W     (ADDR_W),
    .WSHIFT     (WSHIFT)
  ) u_addr (
    .clk       (clk),
    .rst_n     (rst_n),
    .busy      (busy),
    .mem_ready (mem_ready),
    .cur_bank  (cur_bank),
    .mem_addr  (mem_addr),
    .last_word (last_word),
    .bank_end  (bank_end)
  );

  assign mem_we    = busy;
  assign mem_wdata = '0;
endmodule

// File: rtl/wipe_chk.sv
module wipe_chk
  import wipe_pkg::*;
#(
  parameter size_vec_t BANK_BYTES = DEF_BANK_BYTES,
  parameter int        ADDR_W     = 17,
  parameter int        WSHIFT     = 2
)(
  input logic              clk,
  input logic              rst_n,
  input logic              req_wr,
  input mask_t             req_mask,
  input mask_t             pend,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] mem_addr,
  input logic              mem_ready,
  input bank_t             cur_bank,
  input logic              last_word,
  input logic              bank_end
);
  localparam size_vec_t BASE_V = base_vec(BANK_BYTES);

  assert_start_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && req_wr && (|req_mask)) |=> (busy && pend == $past(req_mask)));

  assert_step_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && mem_ready && !last_word) |=> (mem_addr == $past(mem_addr) + ADDR_W'(1 << WSHIFT)));

  assert_range_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (32'(mem_addr) >= BASE_V[cur_bank] &&
              32'(mem_addr) <  BASE_V[cur_bank] + BANK_BYTES[cur_bank]));

  assert_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && !mem_ready) |=> (busy && $stable(mem_addr)));

  assert_active_R6: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> pend[cur_bank]);

  assert_done_idle_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (!busy && pend == '0));

  assert_done_pulse_R7: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  assert_merge_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && req_wr && !bank_end) |=>
      ((pend & $past(req_mask & above(cur_bank))) == $past(req_mask & above(cur_bank))));

  assert_no_lower_R9: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> ((pend & ~above(cur_bank) & ~onehot(cur_bank)) == '0));
endmodule

bind wipe_engine wipe_chk #(
  .BANK_BYTES (BANK_BYTES),
  .ADDR_W     (ADDR_W),
  .WSHIFT     (WSHIFT)
) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .req_wr    (req_wr),
  .req_mask  (req_mask),
  .pend      (pend_mask),
  .busy      (busy),
  .done      (done),
  .mem_addr  (mem_addr),
  .mem_ready (mem_ready),
  .cur_bank  (cur_bank),
  .last_word (last_word),
  .bank_end  (bank_end)
);

// File: tb/tb_wipe_engine.sv
module tb_wipe_engine;
  localparam int AW = 17;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic          rst_n, req_wr, mem_ready;
  logic [3:0]    req_mask, pend_mask;
  logic          busy, done, mem_we;
  logic [AW-1:0] mem_addr;
  logic [31:0]   mem_wdata;

  wipe_engine dut (
    .clk(clk), .rst_n(rst_n), .req_wr(req_wr), .req_mask(req_mask),
    .pend_mask(pend_mask), .busy(busy), .done(done), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_we(mem_we), .mem_ready(mem_ready)
  );

  int checks = 0, errs = 0;
  bit ended = 0;

  // reference model state
  bit       m_busy = 0, m_done = 0, m_stall = 0;
  logic [3:0] m_pend = '0;
  int       m_bank = 0, m_off = 0;
  int       ready_pct = 100;
  int       wcount[4];
  int       order_q[$];
  int       last_bin = -1;

  function automatic int base_of(int b);
    case (b)
      0: return 'h0;
      1: return 'h8000;
      2: return 'h10000;
      default: return 'h1C000;
    endcase
  endfunction

  function automatic int words_of(int b);
    case (b)
      0, 1: return 'h2000;
      2: return 'h3000;
      default: return 'h1000;
    endcase
  endfunction

  function automatic int bin_of(int a);
    for (int b = 3; b >= 0; b--) if (a >= base_of(b)) return b;
    return 0;
  endfunction

  function automatic int lowest(logic [3:0] m);
    for (int b = 0; b < 4; b++) if (m[b]) return b;
    return 0;
  endfunction

  task automatic chk(bit ok, string req, string what, int act, int exp);
    checks++;
    if (!ok) begin
      errs++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  task automatic summary();
    ended = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errs);
    $finish;
  endtask

  // one cycle: drive at the falling edge, compare, observe, advance the model
  task automatic cyc(bit wr, logic [3:0] m);
    bit last;
    int b;
    @(negedge clk);
    req_wr    = wr;
    req_mask  = m;
    mem_ready = ($urandom_range(99) < ready_pct);
    chk(busy == m_busy, "R2", "busy", busy, m_busy);
    chk(pend_mask == m_pend, "R6", "pending", pend_mask, m_pend);
    chk(done == m_done, "R7", "done", done, m_done);
    chk(mem_we == m_busy, "R10", "write enable", mem_we, m_busy);
    if (m_busy) begin
      if (m_stall) chk(int'(mem_addr) == base_of(m_bank) + 4 * m_off, "R4", "held address",
                       int'(mem_addr), base_of(m_bank) + 4 * m_off);
      else         chk(int'(mem_addr) == base_of(m_bank) + 4 * m_off, "R3", "address",
                       int'(mem_addr), base_of(m_bank) + 4 * m_off);
      chk(mem_wdata == 32'h0, "R3", "write data", mem_wdata, 0);
    end
    if (mem_we && mem_ready) begin
      b = bin_of(int'(mem_addr));
      wcount[b]++;
      if (b != last_bin) begin
        order_q.push_back(b);
        last_bin = b;
      end
    end
    m_done  = 0;
    m_stall = m_busy && !mem_ready;
    if (m_busy) begin
      last = 0;
      if (mem_ready) begin
        if (m_off == words_of(m_bank) - 1) begin
          m_pend[m_bank] = 1'b0;
          m_off = 0;
          last  = 1;
        end else m_off++;
      end
      if (wr) for (int i = 0; i < 4; i++) if (i > m_bank && m[i]) m_pend[i] = 1'b1;
      if (last) begin
        if (m_pend == 4'b0) begin
          m_busy = 0;
          m_done = 1;
        end else m_bank = lowest(m_pend);
      end
    end else if (wr && m != 4'b0) begin
      m_pend = m;
      m_busy = 1;
      m_bank = lowest(m);
      m_off  = 0;
    end
  endtask

  // one job: start mask, up to two mid-job requests, then count words per bank
  task automatic run(logic [3:0] m, int pct, int at1, logic [3:0] mm1, int at2, logic [3:0] mm2,
                     logic [3:0] exp_set, string tag);
    int n;
    int k;
    for (int b = 0; b < 4; b++) wcount[b] = 0;
    order_q.delete();
    last_bin  = -1;
    ready_pct = pct;
    cyc(1, m);
    n = 0;
    while ((m_busy || busy) && errs < 20 && n < 40000) begin
      n++;
      if (n == at1)      cyc(1, mm1);
      else if (n == at2) cyc(1, mm2);
      else               cyc(0, 4'b0);
    end
    cyc(0, 4'b0);
    for (int b = 0; b < 4; b++)
      chk(wcount[b] == (exp_set[b] ? words_of(b) : 0), tag, "words written in bank",
          wcount[b], exp_set[b] ? words_of(b) : 0);
    chk(order_q.size() == $countones(exp_set), "R5", "bank count in order",
        order_q.size(), $countones(exp_set));
    k = 0;
    for (int b = 0; b < 4; b++) begin
      if (exp_set[b]) begin
        if (k < order_q.size()) chk(order_q[k] == b, "R5", "bank order", order_q[k], b);
        k++;
      end
    end
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    if (!ended) begin
      errs++;
      $display("FAIL R7 watchdog actual=busy expected=finished");
      summary();
    end
  end

  initial begin
    logic [3:0] rm, mm;
    void'($urandom(32'd4711));
    rst_n = 1'b0; req_wr = 1'b0; req_mask = 4'b0; mem_ready = 1'b1;
    repeat (3) @(negedge clk);
    chk(!busy && !done && !mem_we && pend_mask == 4'b0, "R1", "outputs in reset",
        {busy, done, mem_we, pend_mask}, 0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!busy && !done && !mem_we && pend_mask == 4'b0, "R1", "outputs after reset",
        {busy, done, mem_we, pend_mask}, 0);

    // R2: empty request leaves the engine idle
    cyc(1, 4'b0000);
    cyc(0, 4'b0000);
    chk(!busy && pend_mask == 4'b0, "R2", "empty request ignored", busy, 0);

    // single small bank, full ready (R3)
    run(4'b1000, 100, 0, 4'b0, 0, 4'b0, 4'b1000, "R3");
    // single bank with ready throttled (R4)
    run(4'b0001, 60, 0, 4'b0, 0, 4'b0, 4'b0001, "R4");
    // two non-adjacent banks (R5)
    run(4'b1010, 100, 0, 4'b0, 0, 4'b0, 4'b1010, "R5");
    // every bank (R6)
    run(4'b1111, 100, 0, 4'b0, 0, 4'b0, 4'b1111, "R6");
    // merge above active bank (R8), re-request of active and lower banks (R9)
    run(4'b0001, 100, 50, 4'b0100, 8192 + 100, 4'b1011, 4'b1101, "R8/R9");
    // random job with a random mid-job request
    rm = 4'($urandom_range(1, 15));
    mm = 4'($urandom_range(0, 15));
    begin
      logic [3:0] ex;
      int at;
      at = $urandom_range(10, 3000);
      ex = rm;
      for (int b = 0; b < 4; b++) if (mm[b] && b > lowest(rm)) ex[b] = 1'b1;
      // a mid-job request reaches banks above the one active at that cycle;
      // at <= 3000 and every bank is longer, so the active bank is the lowest selected
      run(rm, 90, at, mm, 0, 4'b0, ex, "R8");
    end
    summary();
  end
endmodule